// File: doc/BRIEF.md
# Nine-Candidate Parallel SAD Engine with Four Subsampled Lanes

This block measures how well one 16×16 block of 8-bit pixels matches nine candidate positions in a reference area. All nine candidates are scored in the same pass. The 256 pixels of the block are split into four phase sub-blocks by 2×2 subsampling, one for each combination of row parity and column parity. Each sub-block goes to its own lane. Each lane has nine accumulating difference elements, one per candidate, so the whole array has 36 of them.

A lane takes one current pixel per cycle, together with the nine reference pixels that the candidates pair with it. After 64 accepted beats, the four lane totals for each candidate are added together. The array then reports all nine full-resolution sums of absolute differences, the lowest of them, and the index of the candidate that holds it. Search control, buffer addressing and vector-cost terms belong to the surrounding logic.

A small state machine sequences the pass through five states:

- IDLE: waits for start.
- LOAD: accepts 64 beats.
- FLUSH: lets the last difference reach the accumulators.
- SUM: adds the four lanes.
- PICK: selects the minimum and raises done.

Its transitions are:

- IDLE→LOAD on start.
- LOAD→LOAD on each beat before the last.
- LOAD→FLUSH on the 64th accepted beat.
- FLUSH→SUM.
- SUM→PICK.
- PICK→IDLE.

Top module: `sad9_array`

## Requirements
- R1: Each sad_all[16c+:16] equals the sum over all 256 block pixels (row r, column k) of |cur − cand_c|. Pixel (r,k) is delivered in lane 2·(r mod 2)+(k mod 2), at beat 8·(r div 2)+(k div 2). The current pixel of lane l is on cur_px[8l+:8], and the candidate-c pixel of lane l is on ref_px[8(9l+c)+:8].
- R2: A start accepted in IDLE clears every accumulator, so a run's results do not depend on earlier runs.
- R3: The worst case (all differences 255) is reported exactly as 65280 for every candidate, with no wrap.
- R4: best_sad is the smallest of the nine sums, and best_idx (0 to 8) is the candidate that holds it.
- R5: When several candidates share the minimum, best_idx is the lowest of their indices.
- R6: A cycle in LOAD with in_valid low consumes no beat and leaves the results unchanged.
- R7: start is ignored while busy is high; the pass in progress completes with unchanged results and timing.
- R8: busy rises on the edge that accepts start. done is a single-cycle pulse on the 67th rising edge after that edge, plus one edge per stalled LOAD cycle, which keeps an unstalled pass within 81 cycles. busy is low when done is high.
- R9: After done, sad_all, best_idx and best_sad hold their values while the block is idle.
- R10: After reset, done, busy, best_idx, best_sad and all of sad_all are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass when the block is idle |
| in_valid | input | 1 | Marks a beat on cur_px/ref_px during LOAD |
| cur_px | input | 32 | Current pixel of each lane, 8 bits per lane |
| ref_px | input | 288 | Reference pixel per lane and candidate, 8 bits each |
| done | output | 1 | One-cycle pulse when the results are final |
| busy | output | 1 | High from start acceptance until done |
| sad_all | output | 144 | Nine 16-bit sums of absolute differences |
| best_idx | output | 4 | Index of the smallest sum |
| best_sad | output | 16 | Smallest sum |

## Verification
The bench uses a free-running edge counter to time each pass. With no stalls, done must rise on the 67th edge after the start edge. Each stall the bench inserts adds exactly one edge, so the expected latency is 67 plus the number of stalls. All sums, the index and the minimum are sampled on the falling edge where done is first seen high, since they are final by then. The bench then checks one falling edge later that done has dropped, and that the results stay stable over further idle cycles.

// File: rtl/sad9_pkg.sv
package sad9_pkg;
    localparam int DEF_LANES = 4;
    localparam int DEF_CANDS = 9;
    localparam int DEF_PIX_W = 8;
    localparam int DEF_BEATS = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FLUSH,
        ST_SUM,
        ST_PICK
    } sad9_state_e;
endpackage

// File: rtl/sad9_pe.sv
// One difference element: registered |a-b| followed by an accumulator.
module sad9_pe #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PIX_W-1:0] cpx,
    input  logic [PIX_W-1:0] rpx,
    output logic [ACC_W-1:0] acc
);
    logic [PIX_W-1:0] diff_q;
    logic             diff_vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q     <= '0;
            diff_vld_q <= 1'b0;
            acc        <= '0;
        end else if (clr) begin
            diff_vld_q <= 1'b0;
            acc        <= '0;
        end else begin
            diff_vld_q <= en;
            if (en) begin
                diff_q <= (cpx > rpx) ? (cpx - rpx) : (rpx - cpx);
            end
            if (diff_vld_q) begin
                acc <= acc + ACC_W'(diff_q);
            end
        end
    end
endmodule

// File: rtl/sad9_lane.sv
// One subsampled phase lane: one difference element per candidate.
module sad9_lane #(
    parameter int CANDS = 9,
    parameter int PIX_W = 8,
    parameter int ACC_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   en,
    input  logic [PIX_W-1:0]       cpx,
    input  logic [CANDS*PIX_W-1:0] rpx,
    output logic [CANDS*ACC_W-1:0] acc
);
    for (genvar c = 0; c < CANDS; c++) begin : g_pe
        sad9_pe #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_pe (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .en   (en),
            .cpx  (cpx),
            .rpx  (rpx[c*PIX_W +: PIX_W]),
            .acc  (acc[c*ACC_W +: ACC_W])
        );
    end
endmodule

// File: rtl/sad9_min.sv
// Combinational minimum search; a strict compare keeps the lowest index on ties.
module sad9_min #(
    parameter int CANDS = 9,
    parameter int SAD_W = 16,
    parameter int IDX_W = 4
) (
    input  logic [CANDS*SAD_W-1:0] sads,
    output logic [IDX_W-1:0]       min_idx,
    output logic [SAD_W-1:0]       min_val
);
    always_comb begin
        min_val = sads[0 +: SAD_W];
        min_idx = '0;
        for (int c = 1; c < CANDS; c++) begin
            if (sads[c*SAD_W +: SAD_W] < min_val) begin
                min_val = sads[c*SAD_W +: SAD_W];
                min_idx = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/sad9_array.sv
module sad9_array
    import sad9_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int CANDS = DEF_CANDS,
    parameter int PIX_W = DEF_PIX_W,
    parameter int BEATS = DEF_BEATS,
    localparam int ACC_W  = PIX_W + $clog2(BEATS),
    localparam int SAD_W  = ACC_W + $clog2(LANES),
    localparam int IDX_W  = $clog2(CANDS),
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         in_valid,
    input  logic [LANES*PIX_W-1:0]       cur_px,
    input  logic [LANES*CANDS*PIX_W-1:0] ref_px,
    output logic                         done,
    output logic                         busy,
    output logic [CANDS*SAD_W-1:0]       sad_all,
    output logic [IDX_W-1:0]             best_idx,
    output logic [SAD_W-1:0]             best_sad
);
    sad9_state_e state_q, state_nxt;
    logic [BEAT_W-1:0] beat_q;
    logic              clr, en;
    logic [LANES-1:0][CANDS*ACC_W-1:0] lane_acc;
    logic [CANDS-1:0][SAD_W-1:0]       tot;
    logic [CANDS-1:0][SAD_W-1:0]       sad_q;
    logic [IDX_W-1:0]                  min_idx;
    logic [SAD_W-1:0]                  min_val;

    assign clr = (state_q == ST_IDLE) && start;
    assign en  = (state_q == ST_LOAD) && in_valid;

    // lanes
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sad9_lane #(.CANDS(CANDS), .PIX_W(PIX_W), .ACC_W(ACC_W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .en   (en),
            .cpx  (cur_px[l*PIX_W +: PIX_W]),
            .rpx  (ref_px[l*CANDS*PIX_W +: CANDS*PIX_W]),
            .acc  (lane_acc[l])
        );
    end

    // cross-lane totals per candidate
    always_comb begin
        for (int c = 0; c < CANDS; c++) begin
            tot[c] = '0;
            for (int l = 0; l < LANES; l++) begin
                tot[c] = tot[c] + SAD_W'(lane_acc[l][c*ACC_W +: ACC_W]);
            end
        end
    end

    sad9_min #(.CANDS(CANDS), .SAD_W(SAD_W), .IDX_W(IDX_W)) u_min (
        .sads   (sad_q),
        .min_idx(min_idx),
        .min_val(min_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_nxt = ST_LOAD;
            ST_LOAD:  if (in_valid && beat_q == BEAT_W'(BEATS - 1)) state_nxt = ST_FLUSH;
            ST_FLUSH: state_nxt = ST_SUM;
            ST_SUM:   state_nxt = ST_PICK;
            ST_PICK:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q   <= '0;
            done     <= 1'b0;
            sad_q    <= '0;
            best_idx <= '0;
            best_sad <= '0;
        end else begin
            done <= (state_q == ST_PICK);
            if (clr) begin
                beat_q <= '0;
            end else if (en) begin
                beat_q <= beat_q + 1'b1;
            end
            if (state_q == ST_SUM) begin
                sad_q <= tot;
            end
            if (state_q == ST_PICK) begin
                best_idx <= min_idx;
                best_sad <= min_val;
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign sad_all = sad_q;
endmodule

// File: rtl/sad9_array_chk.sv
module sad9_array_chk
    import sad9_pkg::*;
#(
    parameter int CANDS = 9,
    parameter int SAD_W = 16,
    parameter int IDX_W = 4,
    parameter int BEATS = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   in_valid,
    input logic                   done,
    input logic                   busy,
    input logic [CANDS*SAD_W-1:0] sad_all,
    input logic [IDX_W-1:0]       best_idx,
    input logic [SAD_W-1:0]       best_sad,
    input sad9_state_e            state
);
    localparam int LAT = BEATS + 3;
    int eff;

    // edges spent in a pass, not counting stalled LOAD cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eff <= 0;
        else if (start && !busy) eff <= 0;
        else if (busy && !(state == ST_LOAD && !in_valid)) eff <= eff + 1;
    end

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (eff == LAT));
    a_r7_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !in_valid) |=> (state == ST_LOAD));
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best_idx < IDX_W'(CANDS)));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(sad_all) && $stable(best_idx) && $stable(best_sad)));

    for (genvar c = 0; c < CANDS; c++) begin : g_cand
        a_r4_not_below: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (sad_all[c*SAD_W +: SAD_W] >= best_sad));
        a_r5_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
            (done && (IDX_W'(c) < best_idx)) |-> (sad_all[c*SAD_W +: SAD_W] > best_sad));
    end
endmodule

bind sad9_array sad9_array_chk #(
    .CANDS(CANDS),
    .SAD_W(SAD_W),
    .IDX_W(IDX_W),
    .BEATS(BEATS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .in_valid(in_valid),
    .done    (done),
    .busy    (busy),
    .sad_all (sad_all),
    .best_idx(best_idx),
    .best_sad(best_sad),
    .state   (state_q)
);

// File: tb/sad9_array_bench.sv
`timescale 1ns/1ps
module sad9_array_bench;
    localparam int LANES = 4;
    localparam int CANDS = 9;
    localparam int SAD_W = 16;
    localparam int LAT   = 67;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic [LANES*8-1:0]       cur_px = '0;
    logic [LANES*CANDS*8-1:0] ref_px = '0;
    logic done, busy;
    logic [CANDS*SAD_W-1:0] sad_all;
    logic [3:0]  best_idx;
    logic [15:0] best_sad;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;

    int cur_b [16][16];
    int area  [24][24];
    int dy [CANDS];
    int dx [CANDS];
    int exp_sad [CANDS];
    int exp_idx;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sad9_array u_sad9_array (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .cur_px(cur_px), .ref_px(ref_px), .done(done), .busy(busy),
        .sad_all(sad_all), .best_idx(best_idx), .best_sad(best_sad)
    );

    task automatic check(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic set_offsets(input int step);
        for (int c = 0; c < CANDS; c++) begin
            dy[c] = 4 + (c / 3 - 1) * step;
            dx[c] = 4 + (c % 3 - 1) * step;
        end
    endtask

    task automatic fill_random(input int step);
        set_offsets(step);
        for (int r = 0; r < 16; r++)
            for (int k = 0; k < 16; k++) cur_b[r][k] = $urandom_range(0, 255);
        for (int r = 0; r < 24; r++)
            for (int k = 0; k < 24; k++) area[r][k] = $urandom_range(0, 255);
    endtask

    task automatic compute_expected();
        for (int c = 0; c < CANDS; c++) begin
            exp_sad[c] = 0;
            for (int r = 0; r < 16; r++)
                for (int k = 0; k < 16; k++) begin
                    int d;
                    d = cur_b[r][k] - area[r + dy[c]][k + dx[c]];
                    exp_sad[c] += (d < 0) ? -d : d;
                end
        end
        exp_idx = 0;
        for (int c = 1; c < CANDS; c++)
            if (exp_sad[c] < exp_sad[exp_idx]) exp_idx = c;
    endtask

    task automatic drive_beat(input int b);
        for (int l = 0; l < LANES; l++) begin
            int r, k;
            r = 2 * (b / 8) + l / 2;
            k = 2 * (b % 8) + l % 2;
            cur_px[l*8 +: 8] = 8'(cur_b[r][k]);
            for (int c = 0; c < CANDS; c++)
                ref_px[(l*CANDS + c)*8 +: 8] = 8'(area[r + dy[c]][k + dx[c]]);
        end
    endtask

    task automatic drive_junk();
        cur_px = $urandom;
        for (int i = 0; i < LANES * CANDS; i++) ref_px[i*8 +: 8] = 8'($urandom);
    endtask

    // one full pass; checks R8 timing on every call
    task automatic run_block(input bit gaps, input bit poke);
        int stalls, t0, lat;
        bit seen;
        stalls = 0;
        @(negedge clk);
        start = 1'b1; in_valid = 1'b0; t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", int'(busy), 1);
        for (int b = 0; b < 64; b++) begin
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                in_valid = 1'b0; start = 1'b0; drive_junk();
                @(negedge clk);
                stalls++;
            end
            drive_beat(b);
            in_valid = 1'b1;
            start = (poke && b == 30);
            @(negedge clk);
        end
        in_valid = 1'b0; start = 1'b0; drive_junk();
        seen = 1'b0;
        for (int w = 0; w < 200 && !seen; w++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        lat = seen ? (cyc - t0 - 1) : -1;
        check("R8 done latency", lat, LAT + stalls);
        check("R8 idle at done", int'(busy), 0);
    endtask

    task automatic check_results(input string tag);
        for (int c = 0; c < CANDS; c++)
            check(tag, int'(sad_all[c*SAD_W +: SAD_W]), exp_sad[c]);
        check({tag, " best_idx"}, int'(best_idx), exp_idx);
        check({tag, " best_sad"}, int'(best_sad), exp_sad[exp_idx]);
        @(negedge clk);
        check("R8 done single pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        check("R10 done", int'(done), 0);
        check("R10 busy", int'(busy), 0);
        check("R10 best_idx", int'(best_idx), 0);
        check("R10 best_sad", int'(best_sad), 0);
        check("R10 sad_all zero", int'(sad_all != '0), 0);
    endtask

    task automatic t_random(input int step, input string tag);
        fill_random(step); compute_expected();
        run_block(1'b0, 1'b0);
        check_results(tag);
    endtask

    task automatic t_match();
        fill_random(3);
        for (int r = 0; r < 16; r++)
            for (int k = 0; k < 16; k++) area[r + dy[5]][k + dx[5]] = cur_b[r][k];
        compute_expected();
        run_block(1'b0, 1'b0);
        check_results("R4 match");
        check("R4 exact match index", int'(best_idx), 5);
        check("R4 exact match zero", int'(best_sad), 0);
    endtask

    task automatic t_tie();
        fill_random(4);
        for (int r = 0; r < 24; r++)
            for (int k = 0; k < 24; k++) area[r][k] = 100;
        compute_expected();
        run_block(1'b0, 1'b0);
        check_results("R5 tie");
        check("R5 lowest index on tie", int'(best_idx), 0);
    endtask

    task automatic t_max();
        set_offsets(4);
        for (int r = 0; r < 16; r++)
            for (int k = 0; k < 16; k++) cur_b[r][k] = 255;
        for (int r = 0; r < 24; r++)
            for (int k = 0; k < 24; k++) area[r][k] = 0;
        compute_expected();
        run_block(1'b0, 1'b0);
        check_results("R3 max");
        check("R3 worst case value", int'(sad_all[8*SAD_W +: SAD_W]), 65280);
    endtask

    task automatic t_stall();
        fill_random(2); compute_expected();
        run_block(1'b1, 1'b0);
        check_results("R6 stalled stream");
    endtask

    task automatic t_busy_start();
        fill_random(4); compute_expected();
        run_block(1'b0, 1'b1);
        check_results("R7 start while busy");
    endtask

    task automatic t_hold();
        logic [CANDS*SAD_W-1:0] snap;
        snap = sad_all;
        repeat (5) @(negedge clk);
        check("R9 sad_all held", int'(sad_all == snap), 1);
        check("R9 best_idx held", int'(best_idx), exp_idx);
        check("R9 best_sad held", int'(best_sad), exp_sad[exp_idx]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_random(4, "R1 step4");
        t_random(2, "R2 back-to-back");
        t_hold();
        t_match();
        t_tie();
        t_max();
        t_stall();
        t_busy_start();
        t_random(1, "R1 step1");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule